// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor request port and a slower main-memory port and keeps a direct-mapped copy of recently read memory blocks. The processor always supplies a full byte address; the controller carves it into a tag, a line index and a byte offset, looks up the single line that index selects, and answers reads from the local copy when the stored tag matches and the line is valid.

A read that misses stalls the processor while the controller fetches the whole block from main memory, one word per transfer, starting at the block-aligned address. The fetched words are written into the line, and the requested word is returned once the last word has arrived. Writes always travel through to main memory as a single word with its byte enables. A write that hits also patches the cached word in the selected byte lanes. A write that misses leaves the cache untouched. Lines never hold modified data, so a line being replaced is overwritten with no traffic back to memory.

Both ports use a valid/ready handshake. The requester raises valid with stable request fields and holds them until ready is seen high. The cache signals completion with a one-cycle ready pulse, and for reads the data is on `cpu_rdata` in that same cycle. The memory side answers a read with `mem_ready` high and the word on `mem_rdata` in the same cycle.

Top module: `wtc_cache`

## Requirements
- R1: The address splits, from the top bit down, into tag, line index and byte offset. With the default parameters (32-bit words, 4 words per line, 16 lines, 16-bit address) the tag is bits [15:8], the index is bits [7:4], the word within the line is bits [3:2] and the byte within the word is bits [1:0]. The line used is the block number modulo the line count.
- R2: Reset clears every valid bit, so the first read of any index is a miss that fetches from memory. After reset `cpu_ready` and `mem_valid` are low.
- R3: A read whose index holds a valid line with a matching tag returns the cached word and causes no memory transfer.
- R4: A read miss issues exactly one memory read for each word of the block. These reads go in ascending word order, start at the block-aligned address, and are each word aligned. The requested word is returned only after the whole block has been loaded.
- R5: A hit needs both the valid bit and a tag match. A read to a loaded index with a different tag misses, replaces the line, and the displaced block then misses when read again.
- R6: Every write, hit or miss, produces exactly one memory write carrying the request's address, data and byte enables (`cpu_be` bit n covers data bits 8n+7:8n).
- R7: A write miss changes no cache contents. The block already held at that index still hits afterwards, and the written address misses when next read.
- R8: A write hit updates only the byte lanes whose enable is set in the cached word. The other lanes and the other words of the line keep their values.
- R9: A write completes toward the processor only after main memory has accepted the word. `cpu_ready` is a single-cycle pulse. While `mem_valid` waits for `mem_ready`, the memory request fields stay stable.
- R10: Lines carry no modified state. Read misses, including replacements, never cause a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Full byte address |
| cpu_be | input | DATA_W/8 | Write byte enables |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accept; carries read data on reads |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address, word aligned on reads |
| mem_be | output | DATA_W/8 | Memory write byte enables |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The hardest situation to reach from the ports is a write miss that lands on an index already holding a different valid block. Here the correct result is that nothing in the array changes. The stimulus first loads one block, then writes to an address with the same index but another tag, and then reads the original block back. Zero memory reads on that readback shows the line survived. A later read of the written address must miss and return the new data. Partial byte-lane merges on a write hit are exposed the same way: after the write, the word and its neighbour are read back, and no memory traffic may occur on either read.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_WRITE,
    ST_RESP
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wtc_data_ram.sv
module wtc_data_ram #(
  parameter int AW     = 6,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [NB-1:0]     be,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we && be[b]) mem_q[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4,
  localparam int NB     = DATA_W / 8,
  localparam int BOFF_W = $clog2(NB),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFF_W,
  localparam int RAM_AW = IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NB-1:0]     cpu_be,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NB-1:0]     mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  tag_rd_idx,
  input  logic              tag_rd_valid,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  output logic              tag_wr_en,
  output logic [TAG_W-1:0]  tag_wr_tag,
  output logic [RAM_AW-1:0] ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [NB-1:0]     ram_be,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  wtc_state_e        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [NB-1:0]     req_be_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [WSEL_W-1:0] beat_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              hit;
  logic              mem_xfer;

  assign req_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr_q[BOFF_W+WSEL_W +: IDX_W];
  assign req_word = req_addr_q[BOFF_W +: WSEL_W];
  assign hit      = tag_rd_valid && (tag_rd_tag == req_tag);
  assign mem_xfer = mem_valid && mem_ready;

  // lookup and fill both act on the latched request's index
  assign tag_rd_idx = req_idx;
  assign tag_wr_tag = req_tag;
  assign tag_wr_en  = (state_q == ST_FILL) && mem_ready && (beat_q == LAST_BEAT);

  // synchronous read: address the RAM from the live request while idle
  assign ram_raddr = (state_q == ST_IDLE) ? cpu_addr[BOFF_W +: RAM_AW]
                                          : {req_idx, req_word};

  always_comb begin
    ram_we    = 1'b0;
    ram_be    = '1;
    ram_waddr = {req_idx, beat_q};
    ram_wdata = mem_rdata;
    if (state_q == ST_FILL) begin
      ram_we = mem_ready;
    end else if (state_q == ST_LOOKUP && req_we_q && hit) begin
      ram_we    = 1'b1;
      ram_be    = req_be_q;
      ram_waddr = {req_idx, req_word};
      ram_wdata = req_wdata_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cpu_valid) state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          beat_q <= '0;
          if (req_we_q)  state_q <= ST_WRITE;
          else if (hit)  state_q <= ST_RESP;
          else           state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_RESP;
          end
        end
        ST_WRITE: begin
          if (mem_ready) state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && cpu_valid) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_be_q    <= cpu_be;
      req_wdata_q <= cpu_wdata;
    end
    if (state_q == ST_LOOKUP && !req_we_q && hit) rdata_q <= ram_rdata;
    if (state_q == ST_FILL && mem_ready && beat_q == req_word) rdata_q <= mem_rdata;
  end

  assign cpu_ready = (state_q == ST_RESP);
  assign cpu_rdata = rdata_q;
  assign mem_valid = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_be    = mem_we ? req_be_q : '1;
  assign mem_wdata = req_wdata_q;
  assign mem_addr  = mem_we ? req_addr_q
                            : {req_tag, req_idx, beat_q, {BOFF_W{1'b0}}};

  logic unused_ok;
  assign unused_ok = mem_xfer;
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4,
  localparam int NB     = DATA_W / 8,
  localparam int BOFF_W = $clog2(NB),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFF_W,
  localparam int RAM_AW = IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NB-1:0]     cpu_be,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NB-1:0]     mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [IDX_W-1:0]  tag_rd_idx;
  logic              tag_rd_valid;
  logic [TAG_W-1:0]  tag_rd_tag;
  logic              tag_wr_en;
  logic [TAG_W-1:0]  tag_wr_tag;
  logic [RAM_AW-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_we;
  logic [NB-1:0]     ram_be;
  logic [RAM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .tag_rd_idx(tag_rd_idx), .tag_rd_valid(tag_rd_valid), .tag_rd_tag(tag_rd_tag),
    .tag_wr_en(tag_wr_en), .tag_wr_tag(tag_wr_tag),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .ram_we(ram_we),
    .ram_be(ram_be), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(tag_rd_idx), .rd_valid(tag_rd_valid), .rd_tag(tag_rd_tag),
    .wr_en(tag_wr_en), .wr_idx(tag_rd_idx), .wr_tag(tag_wr_tag)
  );

  wtc_data_ram #(.AW(RAM_AW), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(ram_we), .be(ram_be), .waddr(ram_waddr),
    .wdata(ram_wdata), .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int BOFF_W = $clog2(DATA_W / 8),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [WSEL_W-1:0] beat_q;
  logic              wr_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q    <= '0;
      wr_seen_q <= 1'b0;
    end else begin
      if (mem_valid && mem_ready && !mem_we) beat_q <= beat_q + 1'b1;
      if (cpu_ready) wr_seen_q <= 1'b0;
      else if (mem_valid && mem_ready && mem_we) wr_seen_q <= 1'b1;
    end
  end

  // R9: a pending memory request holds still
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  // R9: completion is a single-cycle pulse
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R9: a write completes only after memory took the word
  p_write_accepted_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready && cpu_we |-> wr_seen_q);

  // R4: fill beats are word aligned and ascend from the block base
  p_fill_order_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_we |-> mem_addr[BOFF_W +: WSEL_W] == beat_q
                             && mem_addr[BOFF_W-1:0] == '0);

  // R6: the memory write carries the request address
  p_write_addr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_we |-> cpu_valid && cpu_we && mem_addr == cpu_addr);

  // R10: reads never cause memory writes
  p_no_writeback_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && !cpu_we |-> !(mem_valid && mem_we));
endmodule

bind wtc_cache wtc_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/test_wtc_cache.sv
`timescale 1ns/1ps
module test_wtc_cache;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NWORDS = 1 << (AW - 2);
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_valid = 1'b0;
  logic          cpu_ready;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [3:0]    cpu_be = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  wtc_cache i_wtc_cache (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_val(int i);
    return (32'(i) * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [3:0] be);
    logic [DW-1:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  // memory model: fixed latency, one transfer per request
  logic [DW-1:0] mem_arr [NWORDS];
  logic          touched [NWORDS];
  int            lat_cnt = 0;
  int            rd_cnt  = 0;
  int            wr_cnt  = 0;
  logic [AW-1:0] rd_log [8];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) touched[i] <= 1'b0;
      mem_ready <= 1'b0;
      lat_cnt   <= LAT;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_valid) begin
      if (lat_cnt == 0) begin
        int w;
        logic [DW-1:0] cur;
        w   = int'(mem_addr[AW-1:2]);
        cur = touched[w] ? mem_arr[w] : init_val(w);
        mem_ready <= 1'b1;
        lat_cnt   <= LAT;
        if (mem_we) begin
          mem_arr[w] <= merge(cur, mem_wdata, mem_be);
          touched[w] <= 1'b1;
          wr_cnt     <= wr_cnt + 1;
        end else begin
          mem_rdata            <= cur;
          rd_log[rd_cnt % 8]   <= mem_addr;
          rd_cnt               <= rd_cnt + 1;
        end
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
  end

  // golden image of memory, maintained by the bench alone
  logic [DW-1:0] gold [NWORDS];
  initial for (int i = 0; i < NWORDS; i++) gold[i] = init_val(i);

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [3:0] be, output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 1000);
    rd = cpu_rdata;
    cpu_valid = 1'b0;
    @(negedge clk);
    check(!cpu_ready, "R9 ready pulse", 32'(cpu_ready), 32'd0);
    if (we) gold[a[AW-1:2]] = merge(gold[a[AW-1:2]], d, be);
  endtask

  // read and check data plus the number of memory reads and writes it caused
  task automatic rd_chk(input logic [AW-1:0] a, input int exp_rd, input string req);
    logic [DW-1:0] d;
    int c, r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, a, '0, 4'h0, d, c);
    check(d == gold[a[AW-1:2]], req, d, gold[a[AW-1:2]]);
    check(rd_cnt - r0 == exp_rd, {req, " mem reads"}, 32'(rd_cnt - r0), 32'(exp_rd));
    check(wr_cnt == w0, "R10 no write on read", 32'(wr_cnt - w0), 32'd0);
    if (exp_rd == 4) begin
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] ea;
        ea = {a[AW-1:4], 4'h0} + AW'(4 * k);
        check(rd_log[(r0 + k) % 8] == ea, "R4 fill order", 32'(rd_log[(r0 + k) % 8]), 32'(ea));
      end
    end
  endtask

  task automatic wr_chk(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] be,
                        input string req);
    logic [DW-1:0] dummy;
    int c, r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, a, d, be, dummy, c);
    check(wr_cnt - w0 == 1, {req, " one write"}, 32'(wr_cnt - w0), 32'd1);
    check(rd_cnt == r0, {req, " no read"}, 32'(rd_cnt - r0), 32'd0);
    check(mem_arr[a[AW-1:2]] == gold[a[AW-1:2]], {req, " mem word"},
          mem_arr[a[AW-1:2]], gold[a[AW-1:2]]);
    check(c > LAT, "R9 write waits for memory", 32'(c), 32'(LAT + 1));
  endtask

  task automatic t_reset;
    check(!cpu_ready, "R2 ready low after reset", 32'(cpu_ready), 32'd0);
    check(!mem_valid, "R2 mem idle after reset", 32'(mem_valid), 32'd0);
    rd_chk(16'h0104, 4, "R2 first read misses");
  endtask

  task automatic t_read_hit;
    rd_chk(16'h0108, 0, "R3 hit same block");
    rd_chk(16'h010C, 0, "R3 hit last word");
    rd_chk(16'h0100, 0, "R1 hit word zero");
  endtask

  task automatic t_conflict;
    rd_chk(16'h0204, 4, "R5 tag mismatch misses");
    rd_chk(16'h0104, 4, "R5 displaced block misses");
    rd_chk(16'h0114, 4, "R1 next index misses");
    rd_chk(16'h0110, 0, "R1 same line hits");
  endtask

  task automatic t_write_miss;
    wr_chk(16'h0308, 32'hCAFE_F00D, 4'hF, "R6 write miss");
    rd_chk(16'h0108, 0, "R7 held block survives");
    rd_chk(16'h0308, 4, "R7 written address misses");
  endtask

  task automatic t_write_hit;
    wr_chk(16'h0308, 32'hAABB_CCDD, 4'b0101, "R6 write hit");
    rd_chk(16'h0308, 0, "R8 merged lanes");
    rd_chk(16'h030C, 0, "R8 neighbour intact");
    wr_chk(16'h0300, 32'h1122_3344, 4'b1000, "R6 write hit top lane");
    rd_chk(16'h0300, 0, "R8 top lane only");
  endtask

  task automatic t_critical_word;
    rd_chk(16'h0A5C, 4, "R4 miss on last word");
    rd_chk(16'h0B50, 4, "R4 miss on first word");
    rd_chk(16'h0B58, 0, "R4 rest of block loaded");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 16; i++) rd_chk(AW'(16'h4000 + 16 * i + 4), 4, "R1 sweep miss");
    for (int i = 0; i < 16; i++) rd_chk(AW'(16'h4000 + 16 * i + 8), 0, "R3 sweep hit");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_conflict();
    t_write_miss();
    t_write_hit();
    t_critical_word();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule